// File: doc/BRIEF.md
# Quad Half-Bridge Gate Controller

This block is the digital control core for four half-bridge output legs. Each leg has a level input and an enable input. From them it derives a high-side and a low-side gate-enable for that leg. While a leg is disabled, both of its gates are off and the output floats. While it is enabled, the level input picks which of the two gates conducts. When a leg hands over from one gate to the other, both gates stay off for a fixed number of clock cycles. A PWM signal may be applied to the level input or to the enable input. The gates follow it cycle for cycle, except where a dead-time gap has to be inserted.

The block also supervises four conditions:
- Each leg reports a raw overcurrent flag. The flag counts only after it has stayed high for a deglitch interval.
- A confirmed overcurrent, or any over-temperature flag, latches every gate off until a reset.
- An undervoltage flag holds the gates off and recovers without help once the flag drops.
- A low sleep input turns the gates off and drops the charge-pump enable.

An active-low fault output reports the latched fault and the undervoltage condition. All asynchronous inputs pass through two-flop synchronizers. Every input is treated as low after a reset, so the block comes up with its outputs disabled.

Top module: `hbq_ctrl`

## Requirements
- R1: A synchronous high on `rst`, or `rst_req_n` held low, forces every gate off and clears the latched fault. After `rst`, the block is quiet, with `fault_n` = 1 and `cp_en` = 0.
- R2: A change on `leg_en[i]` or `leg_lvl[i]` reaches the gates on the third rising edge after it (two synchronizer stages plus one output register). The gate states follow the inputs as below; turning a gate off is never delayed.

  | `leg_en[i]` | `leg_lvl[i]` | Gates on leg i |
  |---|---|---|
  | 0 | any | both off |
  | 1 | 0 | `gate_lo[i]` only |
  | 1 | 1 | `gate_hi[i]` only |

- R3: `gate_hi[i]` and `gate_lo[i]` are never 1 in the same cycle.
- R4: When a leg hands over from one gate to the other, both gates are off for exactly DEAD_CYC = ceil(CLK_MHZ·DEAD_NS/1000) cycles (10 by default) before the new gate turns on. A gate that turns on when the opposite gate has been off for at least DEAD_CYC cycles is not delayed.
- R5: `oc_flag[i]` must be high for OC_CYC = ceil(CLK_MHZ·OC_NS/1000) consecutive synchronized cycles (300 by default) to be confirmed. A shorter pulse changes neither `fault_n` nor any gate.
- R6: A confirmed overcurrent on any leg, or `ot_flag` high for even one cycle, latches the fault. One edge later every gate turns off and `fault_n` goes low. Both stay so after the flags drop, until an R1 reset.
- R7: While `uv_flag` is high, every gate is off and `fault_n` is 0 (three-edge latency). Both recover without a reset three edges after `uv_flag` falls.
- R8: `sleep_n` low turns every gate off. `cp_en` follows `sleep_n` with a latency of three edges.
- R9: The four legs are independent: inputs on one leg do not change the gates of another leg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req_n | input | 1 | Asynchronous active-low reset request; clears the latched fault |
| sleep_n | input | 1 | Asynchronous; low selects the low-power state |
| leg_lvl | input | 4 | Per-leg level input (1 = high side) |
| leg_en | input | 4 | Per-leg enable (0 = both gates off) |
| oc_flag | input | 4 | Per-leg raw overcurrent flag |
| ot_flag | input | 1 | Over-temperature flag |
| uv_flag | input | 1 | Supply undervoltage flag |
| gate_hi | output | 4 | High-side gate enables |
| gate_lo | output | 4 | Low-side gate enables |
| cp_en | output | 1 | Charge-pump enable |
| fault_n | output | 1 | Active-low fault indicator |

## Verification
A confirmed overcurrent trip can land in the same cycle as a dead-time handover on another leg. To provoke this, the bench keeps toggling one leg's level input while another leg's overcurrent flag runs through its deglitch window. The latch must then win over the pending turn-on: no gate may rise, and the gap must not finish. A cycle-level reference model in the bench judges every cycle of that overlap, and of a long randomized enable/level phase, against the port values.

// File: rtl/hbq_pkg.sv
package hbq_pkg;

    typedef enum logic [1:0] {
        DRV_FLOAT = 2'd0,
        DRV_LOW   = 2'd1,
        DRV_HIGH  = 2'd2
    } drive_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_t;

    function automatic drive_e drive_of(input logic run, input logic en, input logic lvl);
        if (!run || !en) return DRV_FLOAT;
        return lvl ? DRV_HIGH : DRV_LOW;
    endfunction

    function automatic int unsigned ns_to_cyc(input int unsigned mhz, input int unsigned ns);
        int unsigned c;
        c = (mhz * ns + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/hbq_sync.sv
module hbq_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/hbq_ocf.sv
module hbq_ocf #(
    parameter int unsigned OC_CYC = 300
) (
    input  logic clk,
    input  logic rst,
    input  logic oc_s,
    output logic trip
);
    localparam int unsigned CW = (OC_CYC < 2) ? 1 : $clog2(OC_CYC);
    localparam logic [CW-1:0] LAST = CW'(OC_CYC - 1);

    logic [CW-1:0] run_len;

    assign trip = oc_s && (run_len == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (!oc_s) begin
            run_len <= '0;
        end else if (run_len != LAST) begin
            run_len <= run_len + 1'b1;
        end
    end

    generate
        if (OC_CYC >= 2) begin : g_chk
            AST_TRIP_NEEDS_HOLD: assert property (@(posedge clk) disable iff (rst)
                trip |-> $past(oc_s)); // R5
        end
    endgenerate
endmodule

// File: rtl/hbq_leg.sv
module hbq_leg
    import hbq_pkg::*;
#(
    parameter int unsigned DEAD_CYC = 10
) (
    input  logic   clk,
    input  logic   rst,
    input  drive_e want,
    output gate_t  gate
);
    localparam int unsigned GW = $clog2(DEAD_CYC + 1);
    localparam logic [GW-1:0] READY = GW'(DEAD_CYC - 1);

    gate_t         gate_q;
    gate_t         gate_d;
    logic [GW-1:0] gap_hi;   // cycles since high side went off
    logic [GW-1:0] gap_lo;   // cycles since low side went off

    always_comb begin
        gate_d.hi = (want == DRV_HIGH) && !gate_q.lo && (gap_lo >= READY);
        gate_d.lo = (want == DRV_LOW)  && !gate_q.hi && (gap_hi >= READY);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= '0;
            gap_hi <= READY;
            gap_lo <= READY;
        end else begin
            gate_q <= gate_d;
            gap_hi <= gate_q.hi ? '0 : ((gap_hi == READY) ? READY : gap_hi + 1'b1);
            gap_lo <= gate_q.lo ? '0 : ((gap_lo == READY) ? READY : gap_lo + 1'b1);
        end
    end

    assign gate = gate_q;

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(gate_q.hi && gate_q.lo)); // R3
    AST_HANDOVER_LO: assert property (@(posedge clk) disable iff (rst)
        $fell(gate_q.lo) |-> !gate_q.hi); // R4
    AST_HANDOVER_HI: assert property (@(posedge clk) disable iff (rst)
        $fell(gate_q.hi) |-> !gate_q.lo); // R4
    AST_FLOAT_OFF: assert property (@(posedge clk) disable iff (rst)
        (want == DRV_FLOAT) |=> (!gate_q.hi && !gate_q.lo)); // R2
endmodule

// File: rtl/hbq_ctrl.sv
module hbq_ctrl
    import hbq_pkg::*;
#(
    parameter int unsigned CH      = 4,
    parameter int unsigned CLK_MHZ = 100,
    parameter int unsigned DEAD_NS = 100,
    parameter int unsigned OC_NS   = 3000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rst_req_n,
    input  logic          sleep_n,
    input  logic [CH-1:0] leg_lvl,
    input  logic [CH-1:0] leg_en,
    input  logic [CH-1:0] oc_flag,
    input  logic          ot_flag,
    input  logic          uv_flag,
    output logic [CH-1:0] gate_hi,
    output logic [CH-1:0] gate_lo,
    output logic          cp_en,
    output logic          fault_n
);
    localparam int unsigned DEAD_CYC = ns_to_cyc(CLK_MHZ, DEAD_NS);
    localparam int unsigned OC_CYC   = ns_to_cyc(CLK_MHZ, OC_NS);
    localparam int unsigned SW       = 3 * CH + 4;

    logic [SW-1:0] raw_in;
    logic [SW-1:0] syn;
    logic [CH-1:0] lvl_s, en_s, oc_s, trip;
    logic          rq_s, sleep_s, ot_s, uv_s;
    logic          latch_q, fault_q, cp_q, run;

    assign raw_in = {rst_req_n, sleep_n, uv_flag, ot_flag, oc_flag, leg_en, leg_lvl};

    hbq_sync #(.W(SW)) u_sync (.clk(clk), .rst(rst), .d(raw_in), .q(syn));

    assign {rq_s, sleep_s, uv_s, ot_s, oc_s, en_s, lvl_s} = syn;

    assign run = rq_s && sleep_s && !latch_q && !uv_s;

    generate
        for (genvar i = 0; i < CH; i++) begin : g_leg
            gate_t g;
            hbq_ocf #(.OC_CYC(OC_CYC)) u_ocf (
                .clk(clk), .rst(rst), .oc_s(oc_s[i]), .trip(trip[i])
            );
            hbq_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
                .clk(clk), .rst(rst), .want(drive_of(run, en_s[i], lvl_s[i])), .gate(g)
            );
            assign gate_hi[i] = g.hi;
            assign gate_lo[i] = g.lo;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= 1'b0;
            fault_q <= 1'b1;
            cp_q    <= 1'b0;
        end else begin
            latch_q <= rq_s ? (latch_q || (|trip) || ot_s) : 1'b0;
            fault_q <= !(latch_q || uv_s);
            cp_q    <= sleep_s;
        end
    end

    assign cp_en   = cp_q;
    assign fault_n = fault_q;

    AST_RSTREQ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !rq_s |=> !latch_q); // R1
    AST_LATCH_GATES_OFF: assert property (@(posedge clk) disable iff (rst)
        latch_q |=> (gate_hi == '0 && gate_lo == '0 && !fault_n)); // R6
    AST_UV_FAULT: assert property (@(posedge clk) disable iff (rst)
        uv_s |=> (!fault_n && gate_hi == '0 && gate_lo == '0)); // R7
    AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (rst)
        !sleep_s |=> (!cp_en && gate_hi == '0 && gate_lo == '0)); // R8
endmodule

// File: tb/hbq_ctrl_test.sv
module hbq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int D  = 10;
    localparam int OC = 300;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rq_n = 1'b0, slp_n = 1'b0, uv = 1'b0, ot = 1'b0;
    logic [3:0] oc = '0, en = '0, lvl = '0;
    logic [3:0] gate_hi, gate_lo;
    logic cp_en, fault_n;

    int errors = 0;
    int checks = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hbq_ctrl uut (
        .clk(clk), .rst(rst), .rst_req_n(rq_n), .sleep_n(slp_n),
        .leg_lvl(lvl), .leg_en(en), .oc_flag(oc), .ot_flag(ot), .uv_flag(uv),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .cp_en(cp_en), .fault_n(fault_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Reference model built from the requirements (two sync stages, registered outputs)
    logic [15:0] ms1, ms2;
    int  m_cnt[4], m_ghi[4], m_glo[4];
    bit  m_hi[4], m_lo[4];
    bit  m_latch, m_fn, m_cp;

    function automatic bit want_on(input bit run, input bit e, input bit l, input bit side_hi);
        return run && e && (side_hi ? l : !l);
    endfunction

    always @(posedge clk) begin
        bit run, trip_any, nhi, nlo, rq, sl, uvs, ots;
        if (rst) begin
            ms1 = '0; ms2 = '0;
            for (int i = 0; i < 4; i++) begin
                m_cnt[i] = 0; m_hi[i] = 0; m_lo[i] = 0; m_ghi[i] = D - 1; m_glo[i] = D - 1;
            end
            m_latch = 0; m_fn = 1; m_cp = 0;
        end else begin
            rq = ms2[15]; sl = ms2[14]; uvs = ms2[13]; ots = ms2[12];
            run = rq && sl && !m_latch && !uvs;
            trip_any = 0;
            for (int i = 0; i < 4; i++) begin
                if (ms2[8+i] && m_cnt[i] == OC - 1) trip_any = 1;
                nhi = want_on(run, ms2[4+i], ms2[i], 1'b1) && !m_lo[i] && (m_glo[i] >= D - 1);
                nlo = want_on(run, ms2[4+i], ms2[i], 1'b0) && !m_hi[i] && (m_ghi[i] >= D - 1);
                m_ghi[i] = m_hi[i] ? 0 : ((m_ghi[i] >= D - 1) ? D - 1 : m_ghi[i] + 1);
                m_glo[i] = m_lo[i] ? 0 : ((m_glo[i] >= D - 1) ? D - 1 : m_glo[i] + 1);
                m_hi[i] = nhi; m_lo[i] = nlo;
                m_cnt[i] = !ms2[8+i] ? 0 : ((m_cnt[i] >= OC - 1) ? OC - 1 : m_cnt[i] + 1);
            end
            m_fn = !(m_latch || uvs);
            m_latch = rq ? (m_latch || trip_any || ots) : 1'b0;
            m_cp = sl;
            ms2 = ms1;
            ms1 = {rq_n, slp_n, uv, ot, oc, en, lvl};
        end
    end

    always @(negedge clk) begin
        if (mon_on && !done) begin
            logic [3:0] eh, el;
            for (int i = 0; i < 4; i++) begin eh[i] = m_hi[i]; el[i] = m_lo[i]; end
            chk(gate_hi == eh && gate_lo == el, "R2 R4 model gates",
                {gate_hi, gate_lo}, {eh, el});
            chk(fault_n == m_fn && cp_en == m_cp, "R6 R8 model status",
                {fault_n, cp_en}, {m_fn, m_cp});
            chk((gate_hi & gate_lo) == 4'h0, "R3 overlap", gate_hi & gate_lo, 0);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int hold[4];
        void'($urandom(32'd20240611));
        tick(3);
        rst = 1'b0;
        mon_on = 1'b1;
        chk(gate_hi == 0 && gate_lo == 0, "R1 reset gates", {gate_hi, gate_lo}, 0);
        chk(fault_n == 1'b1, "R1 reset fault_n", fault_n, 1);
        chk(cp_en == 1'b0, "R8 reset cp_en", cp_en, 0);

        rq_n = 1; slp_n = 1;
        tick(2); chk(cp_en == 0, "R8 cp_en latency", cp_en, 0);
        tick(1); chk(cp_en == 1, "R8 cp_en on", cp_en, 1);

        en[0] = 1; lvl[0] = 0;
        tick(2); chk(gate_lo[0] == 0, "R2 low side latency", gate_lo[0], 0);
        tick(1); chk(gate_lo[0] == 1, "R2 low side on", gate_lo[0], 1);

        lvl[0] = 1;
        tick(3); chk(gate_lo[0] == 0 && gate_hi[0] == 0, "R4 gap start", {gate_hi[0], gate_lo[0]}, 0);
        tick(D - 1); chk(gate_hi[0] == 0, "R4 gap still off", gate_hi[0], 0);
        tick(1); chk(gate_hi[0] == 1, "R4 high side after gap", gate_hi[0], 1);

        en[1] = 1; lvl[1] = 1;
        tick(3);
        chk(gate_hi[1] == 1 && gate_hi[0] == 1 && gate_lo[1:0] == 0, "R9 legs independent",
            {gate_hi, gate_lo}, {4'b0011, 4'b0000});

        en[0] = 0;
        tick(3); chk(gate_hi[0] == 0 && gate_lo[0] == 0, "R2 disable floats", {gate_hi[0], gate_lo[0]}, 0);

        for (int i = 0; i < 4; i++) hold[i] = 1;
        for (int c = 0; c < 3000; c++) begin
            for (int i = 0; i < 4; i++) begin
                hold[i]--;
                if (hold[i] <= 0) begin
                    en[i]  = ($urandom_range(0, 3) != 0);
                    lvl[i] = $urandom_range(0, 1);
                    hold[i] = 1 + $urandom_range(0, 3 * D);
                end
            end
            @(negedge clk);
        end

        en = 4'hF; lvl = 4'b0101;
        tick(30);
        chk((gate_hi | gate_lo) == 4'hF, "R2 all legs driven", gate_hi | gate_lo, 4'hF);

        oc[1] = 1;
        repeat (OC - 5) @(negedge clk);
        oc[1] = 0;
        tick(5);
        chk(fault_n == 1, "R5 short pulse ignored", fault_n, 1);
        chk((gate_hi | gate_lo) == 4'hF, "R5 gates kept", gate_hi | gate_lo, 4'hF);

        oc[2] = 1;
        for (int c = 0; c < OC + 2; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (c % 7 == 0) lvl[3] = ~lvl[3];
        end
        chk(fault_n == 1, "R6 not yet latched", fault_n, 1);
        tick(1);
        chk(fault_n == 0, "R6 oc latched", fault_n, 0);
        chk(gate_hi == 0 && gate_lo == 0, "R6 gates off", {gate_hi, gate_lo}, 0);
        oc[2] = 0;
        tick(20);
        chk(fault_n == 0 && gate_hi == 0 && gate_lo == 0, "R6 stays latched", {fault_n, gate_hi, gate_lo}, 0);

        rq_n = 0; tick(3); rq_n = 1;
        tick(6);
        chk(fault_n == 1, "R1 rst_req_n clears", fault_n, 1);
        chk((gate_hi | gate_lo) == 4'hF, "R1 gates resume", gate_hi | gate_lo, 4'hF);

        ot = 1; @(negedge clk); ot = 0;
        tick(5);
        chk(fault_n == 0 && gate_hi == 0 && gate_lo == 0, "R6 ot latched", {fault_n, gate_hi, gate_lo}, 0);
        rst = 1; tick(1); rst = 0;
        chk(fault_n == 1 && gate_hi == 0 && gate_lo == 0, "R1 rst clears", {fault_n, gate_hi, gate_lo}, 9'h100);
        tick(4);
        chk((gate_hi | gate_lo) == 4'hF, "R1 gates after rst", gate_hi | gate_lo, 4'hF);

        uv = 1;
        tick(3);
        chk(fault_n == 0 && gate_hi == 0 && gate_lo == 0, "R7 uv holds off", {fault_n, gate_hi, gate_lo}, 0);
        uv = 0;
        tick(3);
        chk(fault_n == 1, "R7 uv recovers fault_n", fault_n, 1);
        chk((gate_hi | gate_lo) == 4'hF, "R7 uv recovers gates", gate_hi | gate_lo, 4'hF);

        slp_n = 0;
        tick(3);
        chk(cp_en == 0 && gate_hi == 0 && gate_lo == 0, "R8 sleep off", {cp_en, gate_hi, gate_lo}, 0);
        slp_n = 1;
        tick(4);
        chk(cp_en == 1, "R8 wake", cp_en, 1);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule